// File: doc/BRIEF.md
# Register exchange unit

This block holds the programmer-visible register set of a small 8/16-bit accumulator CPU and carries out that CPU's two-register exchange instruction. The registers are two 8-bit accumulators A and B, which together form the 16-bit accumulator D, a condition-code register, a direct-page register, four 16-bit index and stack registers, and the program counter.

The sequencer presents an opcode byte and a postbyte and pulses `start_i`. The block captures both operands in one cycle and writes them back in the next. It then reports completion. If the program counter was one of the operands, it also reports a redirected fetch.

Mixed 8/16-bit pairs and unused register codes do not fault. They produce defined results. A separate load port lets the rest of the CPU write any register while the unit is idle.

Top module: `reg_xchg_unit`

## Requirements
- R1: The instruction is accepted when `opcode_i` equals 0x1E. Postbyte bits 7..4 give the first operand code and bits 3..0 give the second. The 16-bit codes are 0=D, 1=X, 2=Y, 3=U, 4=S and 5=PC. The 8-bit codes are 8=A, 9=B, 10=CC and 11=DP. Two operands of the same size swap their values.
- R2: D is always {A,B}, with A as the high byte. A write to D updates both A and B.
- R3: An 8-bit source (A, B, CC or DP) reads as 0xFF in the high byte with the register in the low byte. A 16-bit destination takes that whole word. An 8-bit destination takes the low byte of the other operand's word.
- R4: Codes 6, 7 and 12 to 15 are invalid. An invalid code reads as 0xFFFF, and a write to it changes nothing.
- R5: Reading PC as an operand gives the current PC plus 2. The current PC is taken to be the opcode address.
- R6: Both operands are captured before any write. The second operand's register is written first and the first operand's register last, so on overlap (for example A with D) the first operand's write wins.
- R7: After a legal exchange in which neither code is 5, PC advances by 2 and `branch_o` stays low. If either code is 5, `branch_o` pulses together with `done_o`, and `branch_target_o` equals the new PC.
- R8: If the opcode is not 0x1E, `done_o` and `illegal_o` pulse together and no register changes, PC included.
- R9: When `start_i` is seen while idle, `busy_o` is high for two cycles. `done_o` then pulses for one cycle, and in that same cycle the results are visible. A `start_i` seen while busy is ignored.
- R10: A load (`ld_en_i`) while idle writes `ld_data_i` to the register selected by `ld_sel_i`, using the R1 codes and the R2/R4 rules. A load while busy is ignored.
- R11: After reset all registers are zero and `busy_o`, `done_o`, `illegal_o` and `branch_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an instruction |
| opcode_i | input | 8 | Opcode byte |
| postbyte_i | input | 8 | Operand selector byte |
| ld_en_i | input | 1 | Register load strobe |
| ld_sel_i | input | 4 | Register code for the load |
| ld_data_i | input | 16 | Load value (8-bit targets take the low byte) |
| a_o | output | 8 | Accumulator A |
| b_o | output | 8 | Accumulator B |
| cc_o | output | 8 | Condition-code register |
| dp_o | output | 8 | Direct-page register |
| x_o | output | 16 | Index register X |
| y_o | output | 16 | Index register Y |
| u_o | output | 16 | User stack register |
| s_o | output | 16 | System stack register |
| pc_o | output | 16 | Program counter |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Instruction finished (one-cycle pulse) |
| illegal_o | output | 1 | Opcode rejected, with done_o |
| branch_o | output | 1 | Fetch redirected, with done_o |
| branch_target_o | output | 16 | New fetch address |

## Verification
The bench aims at the overlapping pairs A/D and D/A, because a design that wrote in the wrong order, or captured after writing, would leave a different byte in A. It also targets 8-bit to 16-bit moves, where a design that zero-extended instead of padding with ones would show 0x00 in the high byte, and invalid codes, where a design that dropped the 0xFFFF read or let a write through would corrupt the partner register. PC operands check both the plus-2 read value and the branch strobe. Illegal opcodes must leave PC unadvanced, and loads and starts issued mid-instruction must have no visible effect.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] C_D  = 4'd0;
  localparam logic [CODE_W-1:0] C_X  = 4'd1;
  localparam logic [CODE_W-1:0] C_Y  = 4'd2;
  localparam logic [CODE_W-1:0] C_U  = 4'd3;
  localparam logic [CODE_W-1:0] C_S  = 4'd4;
  localparam logic [CODE_W-1:0] C_PC = 4'd5;
  localparam logic [CODE_W-1:0] C_A  = 4'd8;
  localparam logic [CODE_W-1:0] C_B  = 4'd9;
  localparam logic [CODE_W-1:0] C_CC = 4'd10;
  localparam logic [CODE_W-1:0] C_DP = 4'd11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAP  = 2'd1,
    ST_WB   = 2'd2
  } xchg_state_e;
endpackage

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
  import xchg_pkg::*;
#(
  parameter int          BYTE_W = 8,
  parameter logic [7:0]  EXG_OP = 8'h1E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [BYTE_W-1:0] postbyte_i,
  output logic              busy_o,
  output logic              cap_o,
  output logic              commit_o,
  output logic [CODE_W-1:0] code_first_o,
  output logic [CODE_W-1:0] code_second_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              branch_o
);
  xchg_state_e state_q;
  logic [7:0]        op_q;
  logic [BYTE_W-1:0] pb_q;
  logic              legal, wb, pc_used;

  assign legal         = (op_q == EXG_OP);
  assign wb            = (state_q == ST_WB);
  assign busy_o        = (state_q != ST_IDLE);
  assign cap_o         = (state_q == ST_CAP);
  assign commit_o      = wb && legal;
  assign code_first_o  = pb_q[BYTE_W-1 -: CODE_W];
  assign code_second_o = pb_q[CODE_W-1:0];
  assign pc_used       = (code_first_o == C_PC) || (code_second_o == C_PC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_q      <= '0;
      pb_q      <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      branch_o  <= 1'b0;
    end else begin
      done_o    <= wb;
      illegal_o <= wb && !legal;
      branch_o  <= wb && legal && pc_used;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          op_q    <= opcode_i;
          pb_q    <= postbyte_i;
          state_q <= ST_CAP;
        end
        ST_CAP:  state_q <= ST_WB;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xchg_operand.sv
module xchg_operand
  import xchg_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic [BYTE_W-1:0] cc_i,
  input  logic [BYTE_W-1:0] dp_i,
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic [WORD_W-1:0] u_i,
  input  logic [WORD_W-1:0] s_i,
  input  logic [WORD_W-1:0] pc_seq_i,
  output logic [WORD_W-1:0] val_o
);
  localparam logic [BYTE_W-1:0] PAD = '1;
  logic [WORD_W-1:0] rd;

  always_comb begin
    unique case (code_i)
      C_D:     rd = {a_i, b_i};
      C_X:     rd = x_i;
      C_Y:     rd = y_i;
      C_U:     rd = u_i;
      C_S:     rd = s_i;
      C_PC:    rd = pc_seq_i;
      C_A:     rd = {PAD, a_i};
      C_B:     rd = {PAD, b_i};
      C_CC:    rd = {PAD, cc_i};
      C_DP:    rd = {PAD, dp_i};
      default: rd = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_o <= '0;
    else if (cap_i) val_o <= rd;
  end
endmodule

// File: rtl/xchg_regfile.sv
module xchg_regfile
  import xchg_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PC_STEP = 2,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              ld_en_i,
  input  logic [CODE_W-1:0] ld_sel_i,
  input  logic [WORD_W-1:0] ld_data_i,
  input  logic              commit_i,
  input  logic [CODE_W-1:0] code_first_i,
  input  logic [CODE_W-1:0] code_second_i,
  input  logic [WORD_W-1:0] val_first_i,
  input  logic [WORD_W-1:0] val_second_i,
  output logic [BYTE_W-1:0] a_o,
  output logic [BYTE_W-1:0] b_o,
  output logic [BYTE_W-1:0] cc_o,
  output logic [BYTE_W-1:0] dp_o,
  output logic [WORD_W-1:0] x_o,
  output logic [WORD_W-1:0] y_o,
  output logic [WORD_W-1:0] u_o,
  output logic [WORD_W-1:0] s_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] pc_seq_o,
  output logic [WORD_W-1:0] branch_target_o
);
  localparam int NSTEP = 2;

  logic              wen   [NSTEP];
  logic [CODE_W-1:0] wcode [NSTEP];
  logic [WORD_W-1:0] wval  [NSTEP];
  logic [BYTE_W-1:0] a_n, b_n, cc_n, dp_n;
  logic [WORD_W-1:0] x_n, y_n, u_n, s_n, pc_n;

  assign pc_seq_o = pc_o + WORD_W'(PC_STEP);

  // step 0 lands first; step 1 overrides on overlap
  always_comb begin
    wen[0]   = commit_i || (ld_en_i && !busy_i);
    wcode[0] = commit_i ? code_second_i : ld_sel_i;
    wval[0]  = commit_i ? val_first_i   : ld_data_i;
    wen[1]   = commit_i;
    wcode[1] = code_first_i;
    wval[1]  = val_second_i;
  end

  always_comb begin
    a_n = a_o; b_n = b_o; cc_n = cc_o; dp_n = dp_o;
    x_n = x_o; y_n = y_o; u_n = u_o; s_n = s_o;
    pc_n = commit_i ? pc_seq_o : pc_o;
    for (int k = 0; k < NSTEP; k++) begin
      if (wen[k]) begin
        unique case (wcode[k])
          C_D:     {a_n, b_n} = wval[k];
          C_X:     x_n  = wval[k];
          C_Y:     y_n  = wval[k];
          C_U:     u_n  = wval[k];
          C_S:     s_n  = wval[k];
          C_PC:    pc_n = wval[k];
          C_A:     a_n  = wval[k][BYTE_W-1:0];
          C_B:     b_n  = wval[k][BYTE_W-1:0];
          C_CC:    cc_n = wval[k][BYTE_W-1:0];
          C_DP:    dp_n = wval[k][BYTE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_o <= '0; b_o <= '0; cc_o <= '0; dp_o <= '0;
      x_o <= '0; y_o <= '0; u_o <= '0; s_o <= '0;
      pc_o <= '0; branch_target_o <= '0;
    end else begin
      a_o <= a_n; b_o <= b_n; cc_o <= cc_n; dp_o <= dp_n;
      x_o <= x_n; y_o <= y_n; u_o <= u_n; s_o <= s_n;
      pc_o <= pc_n;
      if (commit_i) branch_target_o <= pc_n;
    end
  end
endmodule

// File: rtl/reg_xchg_unit.sv
module reg_xchg_unit
  import xchg_pkg::*;
#(
  parameter int          BYTE_W  = 8,
  parameter int          PC_STEP = 2,
  parameter logic [7:0]  EXG_OP  = 8'h1E,
  localparam int         WORD_W  = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [BYTE_W-1:0] postbyte_i,
  input  logic              ld_en_i,
  input  logic [3:0]        ld_sel_i,
  input  logic [WORD_W-1:0] ld_data_i,
  output logic [BYTE_W-1:0] a_o,
  output logic [BYTE_W-1:0] b_o,
  output logic [BYTE_W-1:0] cc_o,
  output logic [BYTE_W-1:0] dp_o,
  output logic [WORD_W-1:0] x_o,
  output logic [WORD_W-1:0] y_o,
  output logic [WORD_W-1:0] u_o,
  output logic [WORD_W-1:0] s_o,
  output logic [WORD_W-1:0] pc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              illegal_o,
  output logic              branch_o,
  output logic [WORD_W-1:0] branch_target_o
);
  localparam int NOPS = 2;

  logic              cap, commit;
  logic [CODE_W-1:0] code [NOPS];
  logic [WORD_W-1:0] val  [NOPS];
  logic [WORD_W-1:0] pc_seq;

  xchg_ctrl #(.BYTE_W(BYTE_W), .EXG_OP(EXG_OP)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .opcode_i, .postbyte_i,
    .busy_o, .cap_o(cap), .commit_o(commit),
    .code_first_o(code[0]), .code_second_o(code[1]),
    .done_o, .illegal_o, .branch_o
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    xchg_operand #(.BYTE_W(BYTE_W)) i_opnd (
      .clk_i, .rst_ni, .cap_i(cap), .code_i(code[g]),
      .a_i(a_o), .b_i(b_o), .cc_i(cc_o), .dp_i(dp_o),
      .x_i(x_o), .y_i(y_o), .u_i(u_o), .s_i(s_o),
      .pc_seq_i(pc_seq), .val_o(val[g])
    );
  end

  xchg_regfile #(.BYTE_W(BYTE_W), .PC_STEP(PC_STEP)) i_regs (
    .clk_i, .rst_ni, .busy_i(busy_o),
    .ld_en_i, .ld_sel_i, .ld_data_i,
    .commit_i(commit),
    .code_first_i(code[0]), .code_second_i(code[1]),
    .val_first_i(val[0]), .val_second_i(val[1]),
    .a_o, .b_o, .cc_o, .dp_o, .x_o, .y_o, .u_o, .s_o, .pc_o,
    .pc_seq_o(pc_seq), .branch_target_o
  );
endmodule

// File: rtl/reg_xchg_chk.sv
module reg_xchg_chk #(
  parameter int BYTE_W  = 8,
  parameter int PC_STEP = 2,
  localparam int WORD_W = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              ld_en_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              illegal_o,
  input logic              branch_o,
  input logic [WORD_W-1:0] branch_target_o,
  input logic [WORD_W-1:0] pc_o,
  input logic [WORD_W-1:0] x_o
);
  AST_DONE_AFTER_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o ##1 (busy_o && !done_o) ##1 done_o); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_BRANCH_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o |-> (done_o && !illegal_o && branch_target_o == pc_o)); // R7
  AST_PC_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !illegal_o && !branch_o) |-> pc_o == $past(pc_o) + WORD_W'(PC_STEP)); // R7
  AST_ILLEGAL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(pc_o) && $stable(x_o) && done_o)); // R8
  AST_LOAD_BUSY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ld_en_i && !done_o) |=> (done_o || $stable(x_o))); // R10
endmodule

bind reg_xchg_unit reg_xchg_chk #(.BYTE_W(BYTE_W), .PC_STEP(PC_STEP)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ld_en_i(ld_en_i),
  .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .branch_o(branch_o),
  .branch_target_o(branch_target_o), .pc_o(pc_o), .x_o(x_o)
);

// File: tb/test_reg_xchg_unit.sv
module test_reg_xchg_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = '0;
  logic [7:0]  postbyte_i = '0;
  logic        ld_en_i = 1'b0;
  logic [3:0]  ld_sel_i = '0;
  logic [15:0] ld_data_i = '0;
  logic [7:0]  a_o, b_o, cc_o, dp_o;
  logic [15:0] x_o, y_o, u_o, s_o, pc_o, branch_target_o;
  logic        busy_o, done_o, illegal_o, branch_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  m_a, m_b, m_cc, m_dp;
  logic [15:0] m_x, m_y, m_u, m_s, m_pc;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  reg_xchg_unit i_reg_xchg_unit (.*);

  function automatic logic [15:0] m_read(logic [3:0] c);
    case (c)
      4'd0: return {m_a, m_b};
      4'd1: return m_x;
      4'd2: return m_y;
      4'd3: return m_u;
      4'd4: return m_s;
      4'd5: return m_pc + 16'd2;
      4'd8: return {8'hFF, m_a};
      4'd9: return {8'hFF, m_b};
      4'd10: return {8'hFF, m_cc};
      4'd11: return {8'hFF, m_dp};
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic m_write(logic [3:0] c, logic [15:0] v);
    case (c)
      4'd0: {m_a, m_b} = v;
      4'd1: m_x = v;
      4'd2: m_y = v;
      4'd3: m_u = v;
      4'd4: m_s = v;
      4'd5: m_pc = v;
      4'd8: m_a = v[7:0];
      4'd9: m_b = v[7:0];
      4'd10: m_cc = v[7:0];
      4'd11: m_dp = v[7:0];
      default: ;
    endcase
  endtask

  task automatic check(string req, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_regs(string req);
    check(req, {16'h0, a_o, b_o, cc_o, dp_o, x_o, y_o, u_o, s_o, pc_o},
               {16'h0, m_a, m_b, m_cc, m_dp, m_x, m_y, m_u, m_s, m_pc});
  endtask

  task automatic do_load(logic [3:0] sel, logic [15:0] v);
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_sel_i = sel; ld_data_i = v;
    @(negedge clk_i);
    ld_en_i = 1'b0;
    m_write(sel, v);
  endtask

  // noise: hold start and pulse a load while busy; both must be ignored
  task automatic do_exg(string req, logic [7:0] op, logic [7:0] pb, bit noise);
    logic [15:0] v0, v1;
    bit exp_br, exp_ill;
    @(negedge clk_i);
    start_i = 1'b1; opcode_i = op; postbyte_i = pb;
    @(negedge clk_i);
    start_i = noise;
    if (noise) begin ld_en_i = 1'b1; ld_sel_i = 4'd1; ld_data_i = 16'h5A5A; end
    @(negedge clk_i);
    check({req, " R9 busy"}, {159'h0, busy_o && !done_o}, 160'h1);
    start_i = 1'b0; ld_en_i = 1'b0;
    v0 = m_read(pb[7:4]); v1 = m_read(pb[3:0]);
    exp_ill = (op != 8'h1E);
    exp_br = 1'b0;
    if (!exp_ill) begin
      m_pc = m_pc + 16'd2;
      m_write(pb[3:0], v0);
      m_write(pb[7:4], v1);
      exp_br = (pb[7:4] == 4'd5) || (pb[3:0] == 4'd5);
    end
    @(negedge clk_i);
    check({req, " R9 flags"}, {156'h0, done_o, illegal_o, branch_o, busy_o},
          {156'h0, 1'b1, exp_ill, exp_br, 1'b0});
    check_regs(req);
    if (exp_br) check({req, " R7 target"}, {144'h0, branch_target_o}, {144'h0, m_pc});
    @(negedge clk_i);
    check({req, " R9 single"}, {159'h0, done_o}, 160'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog act=hung exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    m_a = 0; m_b = 0; m_cc = 0; m_dp = 0;
    m_x = 0; m_y = 0; m_u = 0; m_s = 0; m_pc = 0;
    repeat (3) @(negedge clk_i);
    check("R11 reset", {156'h0, busy_o, done_o, illegal_o, branch_o}, 160'h0);
    check_regs("R11 reset regs");
    rst_ni = 1'b1;

    do_load(4'd0, 16'h1234);   // R2 D load splits into A/B
    check_regs("R2 D load");
    do_load(4'd1, 16'hABCD); do_load(4'd2, 16'h1111); do_load(4'd3, 16'h2222);
    do_load(4'd4, 16'h3333); do_load(4'd10, 16'h0077); do_load(4'd11, 16'h0042);
    do_load(4'd5, 16'h0400);
    do_load(4'd6, 16'hDEAD);   // R4 invalid load discarded
    check_regs("R10 loads");

    do_exg("R1 A<->B", 8'h1E, 8'h89, 1'b0);
    do_exg("R1 D<->X", 8'h1E, 8'h01, 1'b0);
    do_exg("R6 A,D", 8'h1E, 8'h80, 1'b0);
    do_exg("R6 D,A", 8'h1E, 8'h08, 1'b0);
    do_exg("R3 X,A", 8'h1E, 8'h18, 1'b0);
    do_exg("R3 CC,Y", 8'h1E, 8'hA2, 1'b0);
    do_exg("R3 DP,B", 8'h1E, 8'hB9, 1'b0);
    do_exg("R4 inv,X", 8'h1E, 8'h61, 1'b0);
    do_exg("R4 U,inv", 8'h1E, 8'h3F, 1'b0);
    do_exg("R5 PC,Y", 8'h1E, 8'h52, 1'b0);
    do_exg("R5 S,PC", 8'h1E, 8'h45, 1'b0);
    do_exg("R7 PC,PC", 8'h1E, 8'h55, 1'b0);
    do_exg("R1 X,X", 8'h1E, 8'h11, 1'b0);
    do_exg("R8 illegal", 8'h12, 8'h89, 1'b0);
    do_exg("R10 busy noise", 8'h1E, 8'h23, 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [7:0] op, pb;
      if ($urandom % 4 == 0)
        do_load(4'($urandom % 16), 16'($urandom));
      op = ($urandom % 10 == 0) ? 8'($urandom) : 8'h1E;
      pb = ($urandom % 5 == 0) ? 8'($urandom) : {4'($urandom % 12), 4'($urandom % 12)};
      do_exg("R6 random", op, pb, ($urandom % 8) == 0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule